// File: doc/BRIEF.md
# Indirect L1 Test-Access Controller

This block turns one register write into one indirect 64-bit access to on-chip L1 memory. Software first loads a base register and, for stores, the two 32-bit test data words. It then writes a data-side test command word. The controller checks the command for reserved bits and for an unsupported tag-array request. If the command is legal, the controller scatters a fixed set of command bits into their address positions, ORs them with the base register, and issues a single 8-byte request on its memory port.

A store sends the pair of test data words as one 64-bit beat, with the low word in the low half. A load writes the returned 64-bit beat back into the same pair of words. The request stays up, with its address held, until the memory raises ready. New commands that arrive before then are refused. Tag-array requests and any instruction-side command produce an unsupported-error pulse and never reach memory.

Top module: `l1_test_access`

## Requirements
- R1: After reset, busy, mem_req and err_valid are 0, both test data words are 0 and the base register holds 0xFF800000.
- R2: The request address is the base register ORed with these fields of the command: command bit 26 goes to address bit 11, bit 24 goes to bit 21, bit 23 goes to bit 15, bits 17:16 go to bits 13:12, and bits 14 and 10:3 stay in place. All other address bits come from the base register alone.
- R3: A data-side command with any bit set in 0xFA7CB801 (bit 2 set) issues no request and pulses err_code 1 (reserved bits).
- R4: A data-side command with bit 2 clear is a tag-array request. It issues no request and pulses err_code 2. This check takes priority over the reserved-bit check.
- R5: When command bit 1 is set, the request is a store: mem_we is 1 and mem_wdata is {high word, low word}.
- R6: When command bit 1 is clear, the request is a load. On completion, the low word takes mem_rdata[31:0] and the high word takes mem_rdata[63:32].
- R7: busy and mem_req rise in the cycle after a legal command is written. They stay high, with mem_addr and mem_we unchanged, until the first clock edge at which mem_ready is 1, and drop after that edge.
- R8: A data-side command written while busy is refused. It pulses err_code 4 and leaves the pending request unchanged.
- R9: A write to the instruction-side command select pulses err_code 3 (unsupported) and issues no request.
- R10: While busy, writes to the base and test data selects are ignored. Select values 5 to 7 are ignored at all times. The selects are 0 for base, 1 for the data-side command, 2 for the low word, 3 for the high word and 4 for the instruction-side command.
- R11: err_valid is a one-cycle pulse in the cycle after the offending write. err_code is 0 whenever err_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select |
| reg_wr_data | input | 32 | Register write value |
| tdata_lo | output | 32 | Low test data word |
| tdata_hi | output | 32 | High test data word |
| busy | output | 1 | Access pending |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a store |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 64 | Store beat |
| mem_rdata | input | 64 | Load beat, sampled with mem_ready |
| mem_ready | input | 1 | Memory completes the pending request |
| err_valid | output | 1 | Error pulse |
| err_code | output | 3 | 1 reserved, 2 tag array, 3 instruction side, 4 busy |

## Verification
The assertions assume that mem_ready is looked at only while a request is pending. They also assume that mem_rdata is valid in the same cycle as mem_ready, and that the register-write inputs carry known values outside reset. The stimulus raises mem_ready only after it has seen mem_req high, holds it for exactly one cycle, and drives mem_rdata alongside it. It changes the register inputs only on falling edges. Refused commands and ignored register writes are sent while a request is held open on purpose, so that the hold and the refusal logic are exercised together.

// File: rtl/l1ta_pkg.sv
package l1ta_pkg;

    localparam int CMD_W = 32;

    // command-to-address bit moves
    localparam int C_WAY   = 26;
    localparam int A_WAY   = 11;
    localparam int C_SIDE  = 24;
    localparam int A_SIDE  = 21;
    localparam int C_BANK  = 23;
    localparam int A_BANK  = 15;
    localparam int C_SUB   = 16;
    localparam int A_SUB   = 12;
    localparam int SUB_W   = 2;
    localparam int C_ARRAY = 2;
    localparam int C_WRITE = 1;

    // bit 14 and bits 10:3 keep their position
    localparam logic [CMD_W-1:0] PASS_MASK = (CMD_W'(1) << 14) | (CMD_W'(8'hFF) << 3);

    function automatic logic [CMD_W-1:0] used_bits();
        logic [CMD_W-1:0] m;
        m = PASS_MASK;
        m[C_WAY]           = 1'b1;
        m[C_SIDE]          = 1'b1;
        m[C_BANK]          = 1'b1;
        m[C_SUB +: SUB_W]  = '1;
        m[C_ARRAY]         = 1'b1;
        m[C_WRITE]         = 1'b1;
        return m;
    endfunction

    localparam logic [CMD_W-1:0] RSV_MASK = ~used_bits();

    typedef enum logic [2:0] {
        SEL_BASE = 3'd0,
        SEL_DCMD = 3'd1,
        SEL_DLO  = 3'd2,
        SEL_DHI  = 3'd3,
        SEL_ICMD = 3'd4
    } sel_e;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_RSV  = 3'd1,
        ERR_TAG  = 3'd2,
        ERR_INST = 3'd3,
        ERR_BUSY = 3'd4
    } err_e;

endpackage

// File: rtl/l1ta_cmd_decode.sv
module l1ta_cmd_decode
    import l1ta_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] cmd,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_flag,
    output logic              tag_sel,
    output logic              rsv_hit
);

    logic [ADDR_W-1:0] scat;

    // pure wiring: each address bit picks at most one command bit
    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
            if (i == A_WAY) begin : g_way
                assign scat[i] = cmd[C_WAY];
            end else if (i == A_SIDE) begin : g_side
                assign scat[i] = cmd[C_SIDE];
            end else if (i == A_BANK) begin : g_bank
                assign scat[i] = cmd[C_BANK];
            end else if (i >= A_SUB && i < A_SUB + SUB_W) begin : g_sub
                assign scat[i] = cmd[C_SUB + i - A_SUB];
            end else if (i < CMD_W) begin : g_low
                if (PASS_MASK[i]) begin : g_pass
                    assign scat[i] = cmd[i];
                end else begin : g_zero
                    assign scat[i] = 1'b0;
                end
            end else begin : g_high
                assign scat[i] = 1'b0;
            end
        end
    endgenerate

    assign addr    = base | scat;
    assign wr_flag = cmd[C_WRITE];
    assign tag_sel = ~cmd[C_ARRAY];
    assign rsv_hit = |(cmd & WORD_W'(RSV_MASK));

endmodule

// File: rtl/l1ta_regfile.sv
module l1ta_regfile
    import l1ta_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                WORD_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_RESET = 32'hFF80_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                busy,
    input  logic                load,
    input  logic [2*WORD_W-1:0] load_data,
    output logic [ADDR_W-1:0]   base,
    output logic [WORD_W-1:0]   data_lo,
    output logic [WORD_W-1:0]   data_hi
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (load) begin
            rf_d.lo = load_data[WORD_W-1:0];
            rf_d.hi = load_data[2*WORD_W-1:WORD_W];
        end else if (wr_en && !busy) begin
            case (sel_e'(wr_sel))
                SEL_BASE: rf_d.base = ADDR_W'(wr_data);
                SEL_DLO:  rf_d.lo   = wr_data;
                SEL_DHI:  rf_d.hi   = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '{base: BASE_RESET, lo: '0, hi: '0};
        end else begin
            rf_q <= rf_d;
        end
    end

    assign base    = rf_q.base;
    assign data_lo = rf_q.lo;
    assign data_hi = rf_q.hi;

endmodule

// File: rtl/l1ta_seq.sv
module l1ta_seq
    import l1ta_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_wr,
    input  logic              dec_tag,
    input  logic              dec_rsv,
    input  logic              mem_ready,
    output logic              busy,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_we,
    output logic              rd_done,
    output logic              err_valid,
    output logic [2:0]        err_code
);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic              err_valid;
        err_e              err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.err_valid = 1'b0;
        s_d.err       = ERR_NONE;

        if (s_q.busy && mem_ready) begin
            s_d.busy = 1'b0;
        end

        if (wr_en) begin
            case (sel_e'(wr_sel))
                SEL_ICMD: s_d.err = ERR_INST;
                SEL_DCMD: begin
                    if (s_q.busy) begin
                        s_d.err = ERR_BUSY;
                    end else if (dec_tag) begin
                        s_d.err = ERR_TAG;
                    end else if (dec_rsv) begin
                        s_d.err = ERR_RSV;
                    end else begin
                        s_d.busy = 1'b1;
                        s_d.addr = dec_addr;
                        s_d.we   = dec_wr;
                    end
                end
                default: ;
            endcase
        end

        s_d.err_valid = (s_d.err != ERR_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, addr: '0, we: 1'b0, err_valid: 1'b0, err: ERR_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign req_addr  = s_q.addr;
    assign req_we    = s_q.we;
    assign rd_done   = s_q.busy && mem_ready && !s_q.we;
    assign err_valid = s_q.err_valid;
    assign err_code  = s_q.err;

endmodule

// File: rtl/l1_test_access.sv
module l1_test_access
    import l1ta_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                WORD_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_RESET = 32'hFF80_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [2:0]          reg_wr_sel,
    input  logic [WORD_W-1:0]   reg_wr_data,
    output logic [WORD_W-1:0]   tdata_lo,
    output logic [WORD_W-1:0]   tdata_hi,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [2*WORD_W-1:0] mem_wdata,
    input  logic [2*WORD_W-1:0] mem_rdata,
    input  logic                mem_ready,
    output logic                err_valid,
    output logic [2:0]          err_code
);

    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_wr;
    logic              dec_tag;
    logic              dec_rsv;
    logic              rd_done;

    l1ta_cmd_decode #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_dec (
        .cmd     (reg_wr_data),
        .base    (base_w),
        .addr    (dec_addr),
        .wr_flag (dec_wr),
        .tag_sel (dec_tag),
        .rsv_hit (dec_rsv)
    );

    l1ta_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .dec_addr  (dec_addr),
        .dec_wr    (dec_wr),
        .dec_tag   (dec_tag),
        .dec_rsv   (dec_rsv),
        .mem_ready (mem_ready),
        .busy      (busy),
        .req_addr  (mem_addr),
        .req_we    (mem_we),
        .rd_done   (rd_done),
        .err_valid (err_valid),
        .err_code  (err_code)
    );

    l1ta_regfile #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .BASE_RESET (BASE_RESET)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .busy      (busy),
        .load      (rd_done),
        .load_data (mem_rdata),
        .base      (base_w),
        .data_lo   (tdata_lo),
        .data_hi   (tdata_hi)
    );

    assign mem_req   = busy;
    assign mem_wdata = {tdata_hi, tdata_lo};

endmodule

// File: rtl/l1ta_checker.sv
module l1ta_checker
    import l1ta_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                mem_req,
    input logic                mem_ready,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [2*WORD_W-1:0] mem_rdata,
    input logic [WORD_W-1:0]   tdata_lo,
    input logic [WORD_W-1:0]   tdata_hi,
    input logic                err_valid,
    input logic [2:0]          err_code,
    input logic [ADDR_W-1:0]   base
);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_addr_has_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & base) == base));

    assert_reserved_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> !$rose(mem_req));

    assert_store_data_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |=> $stable({tdata_hi, tdata_lo}));

    assert_load_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !mem_we |=> {tdata_hi, tdata_lo} == $past(mem_rdata));

    assert_busy_refusal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid && (err_code == ERR_BUSY) |-> $past(mem_req));

    assert_err_code_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid == (err_code != ERR_NONE));

endmodule

bind l1_test_access l1ta_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .tdata_lo  (tdata_lo),
    .tdata_hi  (tdata_hi),
    .err_valid (err_valid),
    .err_code  (err_code),
    .base      (base_w)
);

// File: tb/l1_test_access_test.sv
module l1_test_access_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_sel;
    logic [31:0] reg_wr_data;
    logic [31:0] tdata_lo, tdata_hi;
    logic        busy, mem_req, mem_we, mem_ready, err_valid;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic [2:0]  err_code;

    int tests = 0;
    int fails = 0;

    localparam logic [31:0] RSV = 32'hFA7C_B801;

    always #5 clk = ~clk;

    l1_test_access uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .tdata_lo(tdata_lo), .tdata_hi(tdata_hi),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] c, input logic [31:0] b);
        logic [31:0] e;
        e = b;
        if (c[26]) e = e | 32'h0000_0800;
        if (c[24]) e = e | 32'h0020_0000;
        if (c[23]) e = e | 32'h0000_8000;
        e = e | (((c >> 16) & 32'h3) << 12);
        e = e | (c & 32'h0000_47F8);
        return e;
    endfunction

    // drive one register write; returns on the falling edge where its effect shows
    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = s;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic complete(input logic [63:0] rd);
        mem_ready = 1'b1;
        mem_rdata = rd;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7: watchdog expired, actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int srcs [14] = '{26, 24, 23, 17, 16, 14, 10, 9, 8, 7, 6, 5, 4, 3};
        logic [31:0] cmd;
        logic [63:0] pat;

        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
        mem_ready = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 err_valid", err_valid, 0);
        chk("R1 tdata", {tdata_hi, tdata_lo}, 0);

        // R2/R6/R7 sweep every scattered bit against the reset base
        foreach (srcs[k]) begin
            cmd = (32'h1 << srcs[k]) | 32'h4;
            wr(3'd1, cmd);
            chk("R7 mem_req up", mem_req, 1);
            chk("R7 busy up", busy, 1);
            chk("R2 addr", mem_addr, exp_addr(cmd, 32'hFF80_0000));
            chk("R6 load flag", mem_we, 0);
            pat = {32'hA5A5_0000 | 32'(k), ~(32'h0000_1000 | 32'(srcs[k]))};
            complete(pat);
            chk("R6 load data", {tdata_hi, tdata_lo}, pat);
            chk("R7 mem_req down", mem_req, 0);
        end

        // R2 all fields at once with zero base
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0583_47FC);
        chk("R2 all fields", mem_addr, 32'h0020_FFF8);

        // R7 hold without ready
        repeat (3) begin
            @(negedge clk);
            chk("R7 hold req", mem_req, 1);
            chk("R7 hold addr", mem_addr, 32'h0020_FFF8);
        end

        // R10 ignored writes while busy, R8 refused command
        wr(3'd2, 32'h1111_1111);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_0004);
        chk("R8 err_valid", err_valid, 1);
        chk("R8 err_code", err_code, 4);
        chk("R8 addr kept", mem_addr, 32'h0020_FFF8);
        chk("R10 lo kept while busy", tdata_lo, pat[31:0]);
        complete(64'h0123_4567_89AB_CDEF);
        chk("R6 load after hold", {tdata_hi, tdata_lo}, 64'h0123_4567_89AB_CDEF);

        // base write during busy must not have landed
        wr(3'd1, 32'h0000_0004);
        chk("R10 base kept", mem_addr, 32'h0000_0000);
        complete(64'h0);

        // R5 store
        wr(3'd2, 32'hCAFE_F00D);
        wr(3'd3, 32'h8BAD_BEEF);
        wr(3'd1, 32'h0000_0406);
        chk("R5 we", mem_we, 1);
        chk("R5 wdata", mem_wdata, 64'h8BAD_BEEF_CAFE_F00D);
        chk("R5 addr", mem_addr, 32'h0000_0400);
        wr(3'd3, 32'h0);
        chk("R10 hi kept while busy", mem_wdata, 64'h8BAD_BEEF_CAFE_F00D);
        complete(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 store leaves data", {tdata_hi, tdata_lo}, 64'h8BAD_BEEF_CAFE_F00D);

        // R10 unused selects
        for (int s = 5; s < 8; s++) begin
            wr(3'(s), 32'h5555_AAAA);
            chk("R10 unused sel err", err_valid, 0);
            chk("R10 unused sel req", mem_req, 0);
        end
        chk("R10 unused sel data", {tdata_hi, tdata_lo}, 64'h8BAD_BEEF_CAFE_F00D);

        // R3 reserved sweep and R11 pulse width
        for (int b = 0; b < 32; b++) begin
            if (RSV[b]) begin
                wr(3'd1, (32'h1 << b) | 32'h4);
                chk("R3 err_valid", err_valid, 1);
                chk("R3 err_code", err_code, 1);
                chk("R3 no req", mem_req, 0);
                @(negedge clk);
                chk("R11 pulse ends", err_valid, 0);
                chk("R11 code cleared", err_code, 0);
            end
        end

        // R4 tag array and its priority
        wr(3'd1, 32'h0);
        chk("R4 tag code", err_code, 2);
        chk("R4 no req", mem_req, 0);
        wr(3'd1, RSV);
        chk("R4 tag over reserved", err_code, 2);
        wr(3'd1, 32'h2);
        chk("R4 tag store", err_code, 2);
        chk("R4 tag store no req", mem_req, 0);

        // R9 instruction side
        wr(3'd4, 32'h4);
        chk("R9 err_valid", err_valid, 1);
        chk("R9 err_code", err_code, 3);
        chk("R9 no req", mem_req, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule